// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Character Queue

This block turns an asynchronous serial line into a queue of received characters. The line is sampled with a tick that runs at sixteen times the bit rate. Each character leaves the receiver as a 10-bit word that carries its own parity and framing error flags. It waits in a 16-entry queue until the consumer reads it. Because the flags travel with the character, software always sees which character an error belongs to, even when several characters are pending.

Five frame formats are selected by a 3-bit code. They are seven or eight data bits with or without parity, and nine-bit frames. Each frame has one stop bit. Status outputs show whether the queue is non-empty, at least half full, and full. Two further flags report an overrun and a receive timeout. The timeout is raised when characters are pending and the line has been quiet for a programmable number of bit times. A clear pulse empties the queue.

Top module: `serial_rx_tagged`

## Requirements
- R1: Each queued word holds the character in its low bits. Bit 9 is the framing-error flag. In the parity formats bit 8 is the parity-error flag; in the nine-bit formats bit 8 is the ninth data bit.
- R2: The format code `fmtSel` selects the frame. 001 gives 8 data bits. 011 gives 7 data bits plus parity, and word bit 7 reads 0. 100 gives 9 data bits. 101 gives 8 data bits plus a wake-up bit stored at word bit 8. 111 gives 8 data bits plus parity. The codes 000, 010 and 110 behave as 001. Data is sent least significant bit first.
- R3: The expected parity is odd when `oddPar` is 1 and even when it is 0, counted over the data bits plus the parity bit. A mismatch sets bit 8.
- R4: A stop bit sampled low sets bit 9. The data bits are kept.
- R5: A frame whose data bits, parity bit and stop bit are all low is stored as exactly 10'h200. The parity flag is suppressed in this case, whichever parity is selected.
- R6: A falling edge starts a frame, and the start bit is checked on the 8th tick. If the line is high at that point the receiver returns to idle and stores nothing.
- R7: Characters leave the queue in arrival order, and `rdWord` shows the oldest one. `notEmpty` is high while at least one word is stored. `halfFull` is high at 8 or more words. `fullFlag` is high at 16 words. A pulse on `rdStb` removes one word.
- R8: A character that arrives while the queue is full is discarded, the stored words are kept, and `ovrFlag` is set. Any `rdStb` pulse clears `ovrFlag`.
- R9: `toutFlag` rises when the queue is non-empty, `toutLimit` is non-zero, and `toutLimit` bit times (16 ticks each) have passed since the last arrival. It drops when a character arrives or the queue empties. A `toutLimit` of 0 disables it.
- R10: A `fifoClr` pulse empties the queue and clears `ovrFlag`.
- R11: While `rxEn` is low the line is ignored, any frame in progress is abandoned, and nothing is stored.
- R12: After reset the queue is empty, and `halfFull`, `fullFlag`, `ovrFlag` and `toutFlag` are low.
- R13: All bit timing counts `tick16` pulses, so a slower tick stretches the frame without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| rxLine | input | 1 | serial line, idle high |
| tick16 | input | 1 | one-cycle pulse at 16x the bit rate |
| fmtSel | input | 3 | frame format code |
| oddPar | input | 1 | 1 = odd parity, 0 = even |
| rxEn | input | 1 | receiver enable |
| fifoClr | input | 1 | pulse that empties the queue |
| rdStb | input | 1 | read pulse that pops the oldest word |
| toutLimit | input | 8 | timeout length in bit times, 0 = disabled |
| rdWord | output | 10 | oldest word, valid while notEmpty |
| notEmpty | output | 1 | queue holds at least one word |
| halfFull | output | 1 | queue holds at least 8 words |
| fullFlag | output | 1 | queue holds 16 words |
| ovrFlag | output | 1 | a character was dropped on a full queue |
| toutFlag | output | 1 | receive timeout indication |

## Verification
The in-line assertions check the following on every cycle:
- the queue fill never exceeds its depth;
- an overrun appears only after the queue was full;
- a dropped character leaves the queue full;
- a read or a clear removes the overrun;
- an arrival removes the timeout;
- disabling the receiver forces it idle.

Only the bench scenarios can show the following:
- the content of each word, meaning data alignment per format, parity polarity and break encoding;
- arrival order across a full queue;
- rejection of a false start;
- the timeout's bit-time length.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrShift;
    logic shiftEn;
    logic shiftBit;
    logic push;
    logic stopBit;
  } rxStrobe_t;

  localparam logic [2:0] FMT_D8  = 3'b001;
  localparam logic [2:0] FMT_D7P = 3'b011;
  localparam logic [2:0] FMT_D9  = 3'b100;
  localparam logic [2:0] FMT_D8W = 3'b101;
  localparam logic [2:0] FMT_D8P = 3'b111;

  // bits between the start bit and the stop bit
  function automatic logic [3:0] frameBits(input logic [2:0] f);
    case (f)
      FMT_D9, FMT_D8W, FMT_D8P: frameBits = 4'd9;
      default:                  frameBits = 4'd8;
    endcase
  endfunction

  function automatic logic hasParity(input logic [2:0] f);
    hasParity = (f == FMT_D7P) || (f == FMT_D8P);
  endfunction

endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxLine,
  input  logic      tick,
  input  logic      rxEn,
  input  logic [2:0] fmtSel,
  output rxStrobe_t stb
);

  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2 - 1;

  logic [1:0]    syncQ;
  logic          lineS;
  logic          lineP;
  rxState_t      stateQ, stateD;
  logic [CW-1:0] tickCnt, cntD;
  logic [3:0]    bitIdx, idxD;
  logic [3:0]    nBits;

  assign lineS = syncQ[1];
  assign nBits = frameBits(fmtSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      lineP   <= 1'b1;
      stateQ  <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      syncQ   <= {syncQ[0], rxLine};
      lineP   <= lineS;
      stateQ  <= stateD;
      tickCnt <= cntD;
      bitIdx  <= idxD;
    end
  end

  always_comb begin
    stateD       = stateQ;
    cntD         = tickCnt;
    idxD         = bitIdx;
    stb          = '0;
    stb.shiftBit = lineS;
    stb.stopBit  = lineS;
    if (!rxEn) begin
      stateD = ST_IDLE;
      cntD   = '0;
      idxD   = '0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (lineP && !lineS) begin
            stateD = ST_START;
            cntD   = '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (tickCnt == CW'(MID)) begin
              cntD = '0;
              if (!lineS) begin
                stateD       = ST_DATA;
                idxD         = '0;
                stb.clrShift = 1'b1;
              end else begin
                stateD = ST_IDLE;
              end
            end else begin
              cntD = tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            cntD = tickCnt + 1'b1;
            if (tickCnt == CW'(OVS - 1)) begin
              stb.shiftEn = 1'b1;
              idxD        = bitIdx + 4'd1;
              if (bitIdx == nBits - 4'd1) stateD = ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            cntD = tickCnt + 1'b1;
            if (tickCnt == CW'(OVS - 1)) begin
              stb.push = 1'b1;
              stateD   = ST_IDLE;
            end
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  // R11
  en_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> (stateQ == ST_IDLE));

  // R6
  shift_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftEn |-> (stateQ == ST_DATA));

endmodule

// File: rtl/srx_dpath.sv
module srx_dpath
  import srx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxStrobe_t     stb,
  input  logic          tick,
  input  logic [2:0]    fmtSel,
  input  logic          oddPar,
  input  logic          fifoClr,
  input  logic          rdStb,
  input  logic [TW-1:0] toutLimit,
  output logic [9:0]    rdWord,
  output logic          notEmpty,
  output logic          halfFull,
  output logic          fullFlag,
  output logic          ovrFlag,
  output logic          toutFlag
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OVS);

  logic [8:0]    shReg;
  logic [8:0]    raw;
  logic [8:0]    dataBits;
  logic          pErr, fErr;
  logic [9:0]    newWord;
  logic [9:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   fillCnt;
  logic          doPush, doPop;
  logic [CW-1:0] preCnt;
  logic [TW-1:0] idleCnt;

  // shift register, LSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shReg <= '0;
    else if (stb.clrShift) shReg <= '0;
    else if (stb.shiftEn)  shReg <= {stb.shiftBit, shReg[8:1]};
  end

  // word assembly
  always_comb begin
    raw  = (frameBits(fmtSel) == 4'd9) ? shReg : {1'b0, shReg[8:1]};
    fErr = !stb.stopBit;
    pErr = hasParity(fmtSel) ? ((^raw) ^ oddPar) : 1'b0;
    case (fmtSel)
      FMT_D7P:         dataBits = {2'b00, raw[6:0]};
      FMT_D9, FMT_D8W: dataBits = raw;
      default:         dataBits = {1'b0, raw[7:0]};
    endcase
    if (fErr && (raw == 9'd0))
      newWord = 10'h200;
    else
      newWord = {fErr, (hasParity(fmtSel) ? pErr : dataBits[8]), dataBits[7:0]};
  end

  // queue
  assign notEmpty = (fillCnt != '0);
  assign fullFlag = (fillCnt == (AW+1)'(DEPTH));
  assign halfFull = (fillCnt >= (AW+1)'(DEPTH / 2));
  assign doPush   = stb.push && !fullFlag;
  assign doPop    = rdStb && notEmpty;
  assign rdWord   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !fifoClr) mem[wrPtr] <= newWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
      ovrFlag <= 1'b0;
    end else if (fifoClr) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
      ovrFlag <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      fillCnt <= fillCnt + (AW+1)'(doPush) - (AW+1)'(doPop);
      if (stb.push && fullFlag) ovrFlag <= 1'b1;
      else if (rdStb)           ovrFlag <= 1'b0;
    end
  end

  // timeout in bit times
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      idleCnt <= '0;
    end else if (fifoClr || stb.push || !notEmpty) begin
      preCnt  <= '0;
      idleCnt <= '0;
    end else if (tick) begin
      preCnt <= preCnt + 1'b1;
      if (preCnt == CW'(OVS - 1) && idleCnt != '1) idleCnt <= idleCnt + 1'b1;
    end
  end

  assign toutFlag = notEmpty && (toutLimit != '0) && (idleCnt >= toutLimit);

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= (AW+1)'(DEPTH));

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(fullFlag));

  // R8
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && fullFlag && !rdStb && !fifoClr) |=> fullFlag);

  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !stb.push) |=> !ovrFlag);

  // R9
  tout_arrival_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |=> !toutFlag);

  // R10
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> (!notEmpty && !ovrFlag));

endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
  import srx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxLine,
  input  logic          tick16,
  input  logic [2:0]    fmtSel,
  input  logic          oddPar,
  input  logic          rxEn,
  input  logic          fifoClr,
  input  logic          rdStb,
  input  logic [TW-1:0] toutLimit,
  output logic [9:0]    rdWord,
  output logic          notEmpty,
  output logic          halfFull,
  output logic          fullFlag,
  output logic          ovrFlag,
  output logic          toutFlag
);

  rxStrobe_t stb;

  srx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rxLine (rxLine),
    .tick   (tick16),
    .rxEn   (rxEn),
    .fmtSel (fmtSel),
    .stb    (stb)
  );

  srx_dpath #(.DEPTH(DEPTH), .OVS(OVS), .TW(TW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .tick      (tick16),
    .fmtSel    (fmtSel),
    .oddPar    (oddPar),
    .fifoClr   (fifoClr),
    .rdStb     (rdStb),
    .toutLimit (toutLimit),
    .rdWord    (rdWord),
    .notEmpty  (notEmpty),
    .halfFull  (halfFull),
    .fullFlag  (fullFlag),
    .ovrFlag   (ovrFlag),
    .toutFlag  (toutFlag)
  );

endmodule

// File: tb/serial_rx_tagged_bench.sv
module serial_rx_tagged_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       tick16;
  logic [2:0] fmtSel = 3'b001;
  logic       oddPar = 1'b0;
  logic       rxEn = 1'b1;
  logic       fifoClr = 1'b0;
  logic       rdStb = 1'b0;
  logic [7:0] toutLimit = 8'd0;
  logic [9:0] rdWord;
  logic       notEmpty, halfFull, fullFlag, ovrFlag, toutFlag;

  int nVec = 0;
  int nBad = 0;
  int tickDiv = 1;
  int tickCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) tickCnt <= (tickCnt >= tickDiv - 1) ? 0 : tickCnt + 1;
  assign tick16 = (tickCnt == 0);

  serial_rx_tagged u_serial_rx_tagged (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .tick16(tick16), .fmtSel(fmtSel),
    .oddPar(oddPar), .rxEn(rxEn), .fifoClr(fifoClr), .rdStb(rdStb),
    .toutLimit(toutLimit), .rdWord(rdWord), .notEmpty(notEmpty),
    .halfFull(halfFull), .fullFlag(fullFlag), .ovrFlag(ovrFlag), .toutFlag(toutFlag)
  );

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int nbOf(input logic [2:0] f);
    return (f == 3'b100 || f == 3'b101 || f == 3'b111) ? 9 : 8;
  endfunction

  // payload with correct parity inserted (parity formats), bit flipped if badPar
  function automatic logic [8:0] withPar(input logic [2:0] f, input logic odd,
                                         input logic [8:0] p, input logic badPar);
    logic [8:0] q;
    q = p;
    if (f == 3'b011) q[7] = (^p[6:0]) ^ odd ^ badPar;
    if (f == 3'b111) q[8] = (^p[7:0]) ^ odd ^ badPar;
    return q;
  endfunction

  function automatic logic [9:0] expWord(input logic [2:0] f, input logic odd,
                                         input logic [8:0] p, input logic stopv);
    logic [8:0] raw;
    logic fe, pe;
    raw = (nbOf(f) == 9) ? p : {1'b0, p[7:0]};
    fe  = !stopv;
    if (fe && raw == 9'd0) return 10'h200;
    case (f)
      3'b011:         return {fe, (^raw[7:0]) ^ odd, 1'b0, raw[6:0]};
      3'b111:         return {fe, (^raw) ^ odd, raw[7:0]};
      3'b100, 3'b101: return {fe, raw};
      default:        return {fe, 1'b0, raw[7:0]};
    endcase
  endfunction

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] p, input int nb, input logic stopv);
    int bt;
    bt = 16 * tickDiv;
    rxLine = 1'b0;
    waitCyc(bt);
    for (int i = 0; i < nb; i++) begin
      rxLine = p[i];
      waitCyc(bt);
    end
    rxLine = stopv;
    waitCyc(bt);
    rxLine = 1'b1;
    waitCyc(2 * bt);
  endtask

  task automatic popOne();
    rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic recvOne(input string req, input logic [8:0] p, input logic stopv);
    sendFrame(p, nbOf(fmtSel), stopv);
    chk({req, " notEmpty"}, 32'(notEmpty), 32'd1);
    chk({req, " word"}, 32'(rdWord), 32'(expWord(fmtSel, oddPar, p, stopv)));
    popOne();
    chk({req, " drained"}, 32'(notEmpty), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog act=running exp=finished");
    finishRun();
  end

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);
    // R12 reset state
    chk("R12 notEmpty", 32'(notEmpty), 0);
    chk("R12 halfFull", 32'(halfFull), 0);
    chk("R12 fullFlag", 32'(fullFlag), 0);
    chk("R12 ovrFlag", 32'(ovrFlag), 0);
    chk("R12 toutFlag", 32'(toutFlag), 0);

    // R1 R2: 8-bit format, every value
    fmtSel = 3'b001;
    for (int v = 0; v < 256; v++) recvOne("R2 fmt001", 9'(v), 1'b1);

    // R1 R2: nine-bit formats
    for (int v = 0; v < 512; v += 16) begin
      fmtSel = 3'b100; recvOne("R1 fmt100", 9'(v + 5), 1'b1);
      fmtSel = 3'b101; recvOne("R2 fmt101", 9'(v + 11), 1'b1);
    end

    // R3: parity formats, both polarities, good parity then bad
    for (int o = 0; o < 2; o++) begin
      oddPar = o[0];
      for (int v = 0; v < 16; v++) begin
        fmtSel = 3'b011; recvOne("R3 fmt011 good", withPar(3'b011, oddPar, 9'(v * 7 + 1), 1'b0), 1'b1);
        fmtSel = 3'b111; recvOne("R3 fmt111 good", withPar(3'b111, oddPar, 9'(v * 13 + 2), 1'b0), 1'b1);
        fmtSel = 3'b111; recvOne("R3 fmt111 bad", withPar(3'b111, oddPar, 9'(v * 5 + 3), 1'b1), 1'b1);
      end
    end
    fmtSel = 3'b011; oddPar = 1'b1;
    recvOne("R3 fmt011 bad", withPar(3'b011, 1'b1, 9'h35, 1'b1), 1'b1);

    // R2 reserved code behaves as 8-bit
    fmtSel = 3'b000; oddPar = 1'b0;
    recvOne("R2 reserved", 9'h0C3, 1'b1);

    // R4 framing error keeps data
    fmtSel = 3'b001;
    recvOne("R4 framing", 9'h05A, 1'b0);
    chk("R4 value", 32'(expWord(3'b001, 1'b0, 9'h05A, 1'b0)), 32'h25A);

    // R5 break in parity formats, both polarities
    fmtSel = 3'b111; oddPar = 1'b1;
    sendFrame(9'h000, 9, 1'b0);
    chk("R5 break odd", 32'(rdWord), 32'h200);
    popOne();
    fmtSel = 3'b011; oddPar = 1'b0;
    sendFrame(9'h000, 8, 1'b0);
    chk("R5 break even", 32'(rdWord), 32'h200);
    popOne();

    // R6 false start
    fmtSel = 3'b001;
    rxLine = 1'b0; waitCyc(4); rxLine = 1'b1;
    waitCyc(300);
    chk("R6 false start", 32'(notEmpty), 0);
    recvOne("R6 after false start", 9'h0E7, 1'b1);

    // R11 disabled receiver
    rxEn = 1'b0;
    sendFrame(9'h055, 8, 1'b1);
    chk("R11 disabled", 32'(notEmpty), 0);
    rxEn = 1'b1;
    waitCyc(4);
    recvOne("R11 re-enabled", 9'h0AA, 1'b1);

    // R13 slower tick
    tickDiv = 3; fmtSel = 3'b111; oddPar = 1'b0;
    for (int v = 0; v < 4; v++)
      recvOne("R13 tick div", withPar(3'b111, 1'b0, 9'(v * 61 + 9), 1'b0), 1'b1);
    tickDiv = 1;
    waitCyc(4);

    // R7 R8 fill, overflow, order
    fmtSel = 3'b001;
    for (int i = 0; i < 16; i++) begin
      sendFrame(9'(i * 3 + 1), 8, 1'b1);
      if (i == 6) chk("R7 halfFull at 7", 32'(halfFull), 0);
      if (i == 7) chk("R7 halfFull at 8", 32'(halfFull), 1);
      if (i == 14) chk("R7 not full at 15", 32'(fullFlag), 0);
    end
    chk("R7 full", 32'(fullFlag), 1);
    chk("R8 no overrun yet", 32'(ovrFlag), 0);
    sendFrame(9'h0AA, 8, 1'b1);
    chk("R8 overrun set", 32'(ovrFlag), 1);
    chk("R8 still full", 32'(fullFlag), 1);
    for (int i = 0; i < 16; i++) begin
      chk("R8 R7 order", 32'(rdWord), 32'(i * 3 + 1));
      popOne();
      if (i == 0) chk("R8 cleared by read", 32'(ovrFlag), 0);
    end
    chk("R7 drained", 32'(notEmpty), 0);

    // R10 clear
    for (int i = 0; i < 3; i++) sendFrame(9'(i + 40), 8, 1'b1);
    chk("R10 filled", 32'(notEmpty), 1);
    fifoClr = 1'b1; @(negedge clk); fifoClr = 1'b0;
    chk("R10 empty", 32'(notEmpty), 0);
    recvOne("R10 after clear", 9'h071, 1'b1);

    // R9 timeout
    toutLimit = 8'd6;
    sendFrame(9'h011, 8, 1'b1);
    chk("R9 not yet", 32'(toutFlag), 0);
    waitCyc(100);
    chk("R9 raised", 32'(toutFlag), 1);
    sendFrame(9'h022, 8, 1'b1);
    chk("R9 cleared by arrival", 32'(toutFlag), 0);
    popOne(); popOne();
    chk("R9 empty", 32'(toutFlag), 0);
    toutLimit = 8'd0;
    sendFrame(9'h033, 8, 1'b1);
    waitCyc(200);
    chk("R9 disabled", 32'(toutFlag), 0);
    popOne();

    finishRun();
  end

endmodule